// File: doc/BRIEF.md
# Shift, Rotate and Bit-Test Unit

This block is the byte-wide shift/rotate and single-bit-test datapath of an 8-bit processor core. Each request carries an operation code, a 3-bit bit index, an operand byte, the accumulator byte and the current flag byte. One clock later the block returns a result byte, an updated accumulator byte and a new flag byte. The core's sequencer fetches memory operands, decodes instructions and writes results back. The block only computes values.

There are four groups of operations.
- **Fast accumulator rotates** change the accumulator and disturb few flags.
- **Full rotates and shifts** work on any register value and rebuild the flags from the result.
- **Nibble rotates** move 4-bit groups between the accumulator and a memory byte. The result port carries the new memory byte and the accumulator port carries the new accumulator.
- **Bit test** reports one bit of the operand through the flags and leaves data unchanged.

The same rotate therefore has two flag-update behaviours, depending on whether the fast accumulator form or the full form is chosen.

Flag byte layout, from bit 7 down to bit 0: sign S, zero Z, copy bit Y, half-carry H, copy bit X, parity/overflow PV, subtract N, carry C. PV set means parity is even (an even number of 1 bits).

Top module: `shrot_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `result`, `acc_out` and `flags_out` are all 0 after that edge.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, `result`, `acc_out` and `flags_out` keep their previous values.
- R3: Op codes 0 to 3 rotate the accumulator: 0 is left circular, 1 is right circular, 2 is left through carry, 3 is right through carry. `result` and `acc_out` both carry the rotated byte. S, Z and PV are copied from `flags_in`, H and N become 0, C is the bit shifted out, and Y and X are bits 5 and 3 of the rotated byte.
- R4: Op codes 4 to 7 apply the same four rotates to `operand`. S, Z, Y, X and PV (even parity) come from the result, H and N become 0, C is the bit shifted out, and `acc_out` equals `acc_in`.
- R5: Op code 8 shifts left and fills bit 0 with 0. Op code 10 shifts right and keeps bit 7. Op code 11 shifts right and fills bit 7 with 0. All three set flags as in R4.
- R6: Op code 9 is a left shift identical to op code 8, except that bit 0 of the result is 1.
- R7: Op code 12 (nibble left) gives `result` = {operand[3:0], acc_in[3:0]} and `acc_out` = {acc_in[7:4], operand[7:4]}.
- R8: Op code 13 (nibble right) gives `result` = {acc_in[3:0], operand[7:4]} and `acc_out` = {acc_in[7:4], operand[3:0]}.
- R9: For op codes 12 and 13, S, Z, Y, X and PV (even parity) come from `acc_out`, H and N become 0, and C is copied from `flags_in`.
- R10: Op code 14 tests `operand[bit_sel]`. Z and PV are set when that bit is 0, H becomes 1, N becomes 0, C is copied, Y and X are `operand[5]` and `operand[3]`, `result` equals `operand`, and `acc_out` equals `acc_in`.
- R11: For op code 14, S is 1 only when `bit_sel` is 7 and `operand[7]` is 1; otherwise S is 0.
- R12: Op code 15 is inert: `result` equals `operand`, `acc_out` equals `acc_in`, and `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; inputs are sampled when high |
| op_code | input | 4 | Operation select (encodings in R3 to R12) |
| bit_sel | input | 3 | Bit index for the bit test |
| operand | input | 8 | Register or memory byte operated on |
| acc_in | input | 8 | Accumulator value |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result | output | 8 | Result byte (new memory byte for nibble rotates) |
| acc_out | output | 8 | Updated accumulator value |
| flags_out | output | 8 | Updated flag byte |

## Verification
The only state is the output register. A wrong shift direction, fill bit, nibble route or flag class therefore shows at the ports in the cycle after the request that caused it, and a later request does not hide it. The bench sweeps every op code across all 256 values of the byte being operated on, with both carry values and all bit indexes. This covers the corner values the flags are sensitive to: zero results, bit 7 set, and odd versus even parity.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  localparam int FLAG_W = 8;

  // Flag bit positions inside the flag byte
  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_Y  = 5;
  localparam int FB_H  = 4;
  localparam int FB_X  = 3;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;

  typedef enum logic [3:0] {
    OP_A_RLC = 4'd0,
    OP_A_RRC = 4'd1,
    OP_A_RL  = 4'd2,
    OP_A_RR  = 4'd3,
    OP_RLC   = 4'd4,
    OP_RRC   = 4'd5,
    OP_RL    = 4'd6,
    OP_RR    = 4'd7,
    OP_SLA   = 4'd8,
    OP_SLL   = 4'd9,
    OP_SRA   = 4'd10,
    OP_SRL   = 4'd11,
    OP_NIB_L = 4'd12,
    OP_NIB_R = 4'd13,
    OP_BIT   = 4'd14,
    OP_RSVD  = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    FC_FAST,
    FC_FULL,
    FC_NIB,
    FC_BIT,
    FC_KEEP
  } fclass_e;

  // Field order matches the flag byte, MSB first
  typedef struct packed {
    logic s;
    logic z;
    logic y;
    logic h;
    logic x;
    logic pv;
    logic n;
    logic c;
  } flags_t;

endpackage

// File: rtl/shrot_shift.sv
module shrot_shift import shrot_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] din,
  input  logic              cin,
  output logic [DATA_W-1:0] dout,
  output logic              cout
);

  logic go_left;
  logic fill;

  // One shifter serves every rotate and shift; only direction and fill differ
  always_comb begin
    go_left = 1'b1;
    fill    = 1'b0;
    unique case (op)
      OP_A_RLC, OP_RLC: begin go_left = 1'b1; fill = din[DATA_W-1]; end
      OP_A_RRC, OP_RRC: begin go_left = 1'b0; fill = din[0];        end
      OP_A_RL,  OP_RL:  begin go_left = 1'b1; fill = cin;           end
      OP_A_RR,  OP_RR:  begin go_left = 1'b0; fill = cin;           end
      OP_SLA:           begin go_left = 1'b1; fill = 1'b0;          end
      OP_SLL:           begin go_left = 1'b1; fill = 1'b1;          end
      OP_SRA:           begin go_left = 1'b0; fill = din[DATA_W-1]; end
      OP_SRL:           begin go_left = 1'b0; fill = 1'b0;          end
      default:          begin go_left = 1'b1; fill = 1'b0;          end
    endcase

    if (go_left) begin
      dout = {din[DATA_W-2:0], fill};
      cout = din[DATA_W-1];
    end else begin
      dout = {fill, din[DATA_W-1:1]};
      cout = din[0];
    end
  end

endmodule

// File: rtl/shrot_nibble.sv
module shrot_nibble #(
  parameter int DATA_W = 8
) (
  input  logic              dir_left,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mem,
  output logic [DATA_W-1:0] acc_new,
  output logic [DATA_W-1:0] mem_new
);

  localparam int NIB_W = DATA_W / 2;

  logic [NIB_W-1:0] acc_hi, acc_lo, mem_hi, mem_lo;

  assign acc_hi = acc[DATA_W-1:NIB_W];
  assign acc_lo = acc[NIB_W-1:0];
  assign mem_hi = mem[DATA_W-1:NIB_W];
  assign mem_lo = mem[NIB_W-1:0];

  // The accumulator's upper half never moves; three low-side nibbles rotate
  always_comb begin
    if (dir_left) begin
      mem_new = {mem_lo, acc_lo};
      acc_new = {acc_hi, mem_hi};
    end else begin
      mem_new = {acc_lo, mem_hi};
      acc_new = {acc_hi, mem_lo};
    end
  end

endmodule

// File: rtl/shrot_flag_gen.sv
module shrot_flag_gen import shrot_pkg::*; #(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  fclass_e           fclass,
  input  logic [DATA_W-1:0] value,
  input  logic              cout,
  input  flags_t            fin,
  input  logic [IDX_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] tested,
  output flags_t            fout
);

  logic is_zero;
  logic par_even;
  logic tbit;
  logic top_sel;

  assign is_zero  = (value == '0);
  assign par_even = ~^value;
  assign tbit     = tested[bit_sel];
  assign top_sel  = (bit_sel == IDX_W'(DATA_W - 1));

  always_comb begin
    fout = fin;
    unique case (fclass)
      FC_FAST: begin
        fout.y = value[FB_Y];
        fout.x = value[FB_X];
        fout.h = 1'b0;
        fout.n = 1'b0;
        fout.c = cout;
      end
      FC_FULL, FC_NIB: begin
        fout.s  = value[DATA_W-1];
        fout.z  = is_zero;
        fout.y  = value[FB_Y];
        fout.h  = 1'b0;
        fout.x  = value[FB_X];
        fout.pv = par_even;
        fout.n  = 1'b0;
        fout.c  = (fclass == FC_FULL) ? cout : fin.c;
      end
      FC_BIT: begin
        fout.s  = tbit & top_sel;
        fout.z  = ~tbit;
        fout.y  = tested[FB_Y];
        fout.h  = 1'b1;
        fout.x  = tested[FB_X];
        fout.pv = ~tbit;
        fout.n  = 1'b0;
        fout.c  = fin.c;
      end
      default: fout = fin;
    endcase
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit import shrot_pkg::*; #(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic [IDX_W-1:0]  bit_sel,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] acc_out,
  output logic [FLAG_W-1:0] flags_out
);

  op_e               op;
  logic              fast_op;
  logic [DATA_W-1:0] sh_src, sh_out;
  logic              sh_cout;
  logic [DATA_W-1:0] nib_acc, nib_mem;
  logic [DATA_W-1:0] nxt_res, nxt_acc, flag_val;
  fclass_e           fclass;
  flags_t            fin, fnew;

  assign op      = op_e'(op_code);
  assign fin     = flags_t'(flags_in);
  assign fast_op = (op inside {OP_A_RLC, OP_A_RRC, OP_A_RL, OP_A_RR});
  assign sh_src  = fast_op ? acc_in : operand;

  shrot_shift #(.DATA_W(DATA_W)) u_shift (
    .op   (op),
    .din  (sh_src),
    .cin  (fin.c),
    .dout (sh_out),
    .cout (sh_cout)
  );

  shrot_nibble #(.DATA_W(DATA_W)) u_nibble (
    .dir_left (op == OP_NIB_L),
    .acc      (acc_in),
    .mem      (operand),
    .acc_new  (nib_acc),
    .mem_new  (nib_mem)
  );

  always_comb begin
    nxt_res  = operand;
    nxt_acc  = acc_in;
    flag_val = operand;
    fclass   = FC_KEEP;
    unique case (op)
      OP_A_RLC, OP_A_RRC, OP_A_RL, OP_A_RR: begin
        nxt_res  = sh_out;
        nxt_acc  = sh_out;
        flag_val = sh_out;
        fclass   = FC_FAST;
      end
      OP_RLC, OP_RRC, OP_RL, OP_RR,
      OP_SLA, OP_SLL, OP_SRA, OP_SRL: begin
        nxt_res  = sh_out;
        flag_val = sh_out;
        fclass   = FC_FULL;
      end
      OP_NIB_L, OP_NIB_R: begin
        nxt_res  = nib_mem;
        nxt_acc  = nib_acc;
        flag_val = nib_acc;
        fclass   = FC_NIB;
      end
      OP_BIT:  fclass = FC_BIT;
      default: fclass = FC_KEEP;
    endcase
  end

  shrot_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .fclass  (fclass),
    .value   (flag_val),
    .cout    (sh_cout),
    .fin     (fin),
    .bit_sel (bit_sel),
    .tested  (operand),
    .fout    (fnew)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      acc_out   <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        acc_out   <= nxt_acc;
        flags_out <= fnew;
      end
    end
  end

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk import shrot_pkg::*; #(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        op_code,
  input logic [IDX_W-1:0]  bit_sel,
  input logic [DATA_W-1:0] operand,
  input logic [FLAG_W-1:0] flags_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flags_out
);

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags_out))); // R2

  AST_FAST_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code < 4'd4) |=>
      (flags_out[FB_S] == $past(flags_in[FB_S]) &&
       flags_out[FB_Z] == $past(flags_in[FB_Z]) &&
       flags_out[FB_PV] == $past(flags_in[FB_PV]))); // R3

  AST_SRA_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_SRA) |=>
      result[DATA_W-1] == $past(operand[DATA_W-1])); // R5

  AST_SLL_LSB: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_SLL) |=> result[0]); // R6

  AST_NIB_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_code == OP_NIB_L || op_code == OP_NIB_R)) |=>
      (flags_out[FB_C] == $past(flags_in[FB_C]) && !flags_out[FB_H])); // R9

  AST_BIT_HN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_BIT) |=>
      (flags_out[FB_H] && !flags_out[FB_N] && result == $past(operand))); // R10

  AST_BIT_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_BIT && bit_sel != IDX_W'(DATA_W - 1)) |=>
      !flags_out[FB_S]); // R11

  AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code == OP_RSVD) |=> flags_out == $past(flags_in)); // R12

endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_code   (op_code),
  .bit_sel   (bit_sel),
  .operand   (operand),
  .flags_in  (flags_in),
  .out_valid (out_valid),
  .result    (result),
  .flags_out (flags_out)
);

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] operand = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] flags_in = '0;
  logic       out_valid;
  logic [7:0] result, acc_out, flags_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  shrot_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .bit_sel(bit_sel), .operand(operand), .acc_in(acc_in),
    .flags_in(flags_in), .out_valid(out_valid), .result(result),
    .acc_out(acc_out), .flags_out(flags_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d opd=%h acc=%h f=%h idx=%0d got=%h exp=%h",
               tag, op_code, operand, acc_in, flags_in, bit_sel, got, exp);
    end
  endtask

  // S, Z, Y, X and even parity of a byte, placed in their flag positions
  function automatic int szp(input int x);
    int p = 1;
    for (int i = 0; i < 8; i++) p ^= (x >> i) & 1;
    return (x & 128) | ((x == 0) ? 64 : 0) | (x & 40) | (p ? 4 : 0);
  endfunction

  // Returns {acc_out, result, flags_out}
  function automatic logic [23:0] model(input int op, input int idx, input int opd,
                                        input int a, input int f);
    int r = opd, ao = a, fo = f, c = 0, v, t;
    v = (op < 4) ? a : opd;
    case (op)
      0, 4: begin r = ((v << 1) | (v >> 7)) & 255; c = v >> 7; end
      1, 5: begin r = (v >> 1) | ((v & 1) << 7);   c = v & 1;  end
      2, 6: begin r = ((v << 1) | (f & 1)) & 255;  c = v >> 7; end
      3, 7: begin r = (v >> 1) | ((f & 1) << 7);   c = v & 1;  end
      8:    begin r = (v << 1) & 255;              c = v >> 7; end
      9:    begin r = ((v << 1) | 1) & 255;        c = v >> 7; end
      10:   begin r = (v >> 1) | (v & 128);        c = v & 1;  end
      11:   begin r = v >> 1;                      c = v & 1;  end
      12:   begin r = ((opd << 4) & 240) | (a & 15); ao = (a & 240) | (opd >> 4); end
      13:   begin r = ((a & 15) << 4) | (opd >> 4);   ao = (a & 240) | (opd & 15); end
      default: ;
    endcase
    if (op < 4) begin
      ao = r;
      fo = (f & (128 | 64 | 4)) | (r & 40) | c;
    end else if (op < 12) begin
      fo = szp(r) | c;
    end else if (op < 14) begin
      fo = szp(ao) | (f & 1);
    end else if (op == 14) begin
      t  = (opd >> idx) & 1;
      fo = (t ? 0 : (64 | 4)) | ((idx == 7 && t == 1) ? 128 : 0) | 16 | (opd & 40) | (f & 1);
    end
    return {ao[7:0], r[7:0], fo[7:0]};
  endfunction

  function automatic string tag_of(input int op, input int idx);
    if (op < 4) return "R3";
    if (op < 8) return "R4";
    if (op == 9) return "R6";
    if (op < 12) return "R5";
    if (op == 12) return "R7";
    if (op == 13) return "R8";
    if (op == 14) return (idx == 7) ? "R11" : "R10";
    return "R12";
  endfunction

  initial begin
    logic [23:0] exp;
    logic [7:0]  keep_r, keep_a, keep_f;
    // Reset state
    repeat (3) @(negedge clk);
    chk("R1", {out_valid, result, acc_out, flags_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", {31'b0, out_valid}, 32'h0);

    // Sweep every op code over all byte values, carries and bit indexes
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 2048; k++) begin
        int v, idx, cf, a_v, o_v, f_v;
        v   = k & 255;
        idx = (k >> 8) & 7;
        cf  = (k >> 8) & 1;
        a_v = (op < 4) ? v : ((k * 37 + 11) & 255);
        o_v = (op < 4) ? ((k * 53) & 255) : v;
        f_v = (((k * 29) ^ 90) & 254) | cf;
        in_valid = 1'b1;
        op_code  = 4'(op);
        bit_sel  = 3'(idx);
        operand  = 8'(o_v);
        acc_in   = 8'(a_v);
        flags_in = 8'(f_v);
        @(negedge clk);
        exp = model(op, idx, o_v, a_v, f_v);
        if (op == 12 || op == 13) begin
          chk(tag_of(op, idx), {16'b0, acc_out, result}, {16'b0, exp[23:8]});
          chk("R9", {24'b0, flags_out}, {24'b0, exp[7:0]});
        end else begin
          chk(tag_of(op, idx), {8'b0, acc_out, result, flags_out}, {8'b0, exp});
        end
        if (k == 0) chk("R2", {31'b0, out_valid}, 32'h1);
      end
    end

    // Idle cycles: outputs hold while inputs change
    keep_r = result; keep_a = acc_out; keep_f = flags_out;
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b0;
      op_code  = 4'(i + 4);
      operand  = 8'(i * 71 + 5);
      acc_in   = 8'(i * 19 + 3);
      flags_in = 8'(i * 97 + 1);
      @(negedge clk);
      chk("R2", {7'b0, out_valid, keep_r, keep_a, keep_f},
                {8'b0, result, acc_out, flags_out});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule